// File: doc/BRIEF.md
# Stereo Zero-Run Detector

This block watches a two-channel PCM sample stream that arrives as one left/right pair per frame. A frame is marked by a single-cycle strobe in the system-clock domain. The block counts consecutive frames in which both channels are exactly zero. After a fixed, parameterised number of such frames, it raises a registered, active-high flag. The flag drops on the first frame that carries any nonzero sample. Downstream logic can use it to power down or gate an idle output path.

The run is counted in frames, not in clock cycles. The spacing between strobes therefore does not matter. Sample values present on cycles without a strobe are never looked at. The counter saturates at the threshold, so arbitrarily long silence keeps the flag up without wrapping.

Top module: `stereo_zero_detect`

## Requirements
- R1: Only cycles with `frameStrobe` high are counted. On any cycle with the strobe low, the flag holds its value whatever the sample inputs carry.
- R2: After RUN_LEN (default 8192) consecutive strobed frames with both samples zero, `zeroFlag` is 1 in the cycle after the strobe of the RUN_LEN-th such frame. After RUN_LEN-1 such frames it is still 0.
- R3: A frame counts as zero only if the left and the right sample are both zero in that same frame. A frame with one channel zero and the other nonzero breaks the run.
- R4: A strobed frame with a nonzero sample on either channel drives `zeroFlag` to 0 at the clock edge of that strobe.
- R5: A nonzero frame restarts the run. A further RUN_LEN consecutive zero frames are needed before the flag rises again.
- R6: The run count saturates at RUN_LEN, so the flag stays 1 for any number of zero frames beyond the threshold, including more than twice RUN_LEN.
- R7: Synchronous reset (`rst` high at a clock edge) clears the flag and the run count. A full run of RUN_LEN zero frames is then needed again.
- R8: The sample width (SAMPLE_W, default 24) and the run length (RUN_LEN) are module parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frameStrobe | input | 1 | One-cycle pulse per frame; samples are valid while it is high |
| leftSample | input | SAMPLE_W | Signed left-channel sample |
| rightSample | input | SAMPLE_W | Signed right-channel sample |
| zeroFlag | output | 1 | Registered flag, high after a full zero run |

## Verification
On every cycle, the embedded assertions check the following:
- the flag holds between strobes;
- a nonzero frame forces the flag low and the count to zero on the next cycle;
- the flag rises only on a zero frame that completes the run;
- the saturated count stays at its limit.

Only the bench scenarios can show the exact frame on which the flag rises, with nothing early at RUN_LEN-1. They also cover rejection of one-sided zeros on either channel, restart after an interruption or a reset, and survival past twice the threshold without wrap. Nonzero samples are driven between strobes to show they are ignored.

// File: rtl/zd_pkg.sv
package zd_pkg;
  typedef struct packed {
    logic advance;  // strobed frame with both channels zero
    logic restart;  // strobed frame with a nonzero channel
  } zdStrobe_t;
endpackage

// File: rtl/zd_datapath.sv
module zd_datapath
  import zd_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] leftSample,
  input  logic signed [SAMPLE_W-1:0] rightSample,
  input  zdStrobe_t                  strobes,
  output logic                       bothZero,
  output logic                       nearFull
);
  localparam int NUM_CH = 2;
  localparam int CNT_W  = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);

  logic [SAMPLE_W-1:0] chanData [NUM_CH];
  logic [NUM_CH-1:0]   chanZero;
  logic [CNT_W-1:0]    runCount;

  assign chanData[0] = leftSample;
  assign chanData[1] = rightSample;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign chanZero[ch] = (chanData[ch] == '0);
  end

  assign bothZero = &chanZero;
  assign nearFull = (runCount >= RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      runCount <= '0;
    end else if (strobes.restart) begin
      runCount <= '0;
    end else if (strobes.advance && (runCount != RUN_MAX)) begin
      runCount <= runCount + 1'b1;
    end
  end

  // R5: a nonzero frame empties the run count
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (rst)
    strobes.restart |=> (runCount == '0));

  // R6: once at the limit, further zero frames keep the count there
  a_r6_count_saturates: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && runCount == RUN_MAX) |=> (runCount == RUN_MAX));

  // R1: count is untouched on cycles without a strobe
  a_r1_count_idle: assert property (@(posedge clk) disable iff (rst)
    !(strobes.advance || strobes.restart) |=> $stable(runCount));
endmodule

// File: rtl/zd_control.sv
module zd_control
  import zd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      frameStrobe,
  input  logic      bothZero,
  input  logic      nearFull,
  output zdStrobe_t strobes,
  output logic      zeroFlag
);
  always_comb begin
    strobes.advance = frameStrobe && bothZero;
    strobes.restart = frameStrobe && !bothZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zeroFlag <= 1'b0;
    end else if (strobes.restart) begin
      zeroFlag <= 1'b0;
    end else if (strobes.advance && nearFull) begin
      zeroFlag <= 1'b1;
    end
  end

  // R1: flag holds on cycles without a frame strobe
  a_r1_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
    !frameStrobe |=> $stable(zeroFlag));

  // R4: a strobed nonzero frame drops the flag at that edge
  a_r4_nonzero_clears: assert property (@(posedge clk) disable iff (rst)
    (frameStrobe && !bothZero) |=> !zeroFlag);

  // R2: the flag only rises on a zero frame that completes the run
  a_r2_rise_on_full_run: assert property (@(posedge clk) disable iff (rst)
    $rose(zeroFlag) |-> $past(frameStrobe && bothZero && nearFull));
endmodule

// File: rtl/stereo_zero_detect.sv
module stereo_zero_detect
  import zd_pkg::*;
#(
  parameter int SAMPLE_W = 24,   // R8
  parameter int RUN_LEN  = 8192  // R8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frameStrobe,
  input  logic signed [SAMPLE_W-1:0] leftSample,
  input  logic signed [SAMPLE_W-1:0] rightSample,
  output logic                       zeroFlag
);
  zdStrobe_t strobes;
  logic      bothZero;
  logic      nearFull;

  zd_datapath #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .leftSample (leftSample),
    .rightSample(rightSample),
    .strobes    (strobes),
    .bothZero   (bothZero),
    .nearFull   (nearFull)
  );

  zd_control u_control (
    .clk        (clk),
    .rst        (rst),
    .frameStrobe(frameStrobe),
    .bothZero   (bothZero),
    .nearFull   (nearFull),
    .strobes    (strobes),
    .zeroFlag   (zeroFlag)
  );
endmodule

// File: tb/stereo_zero_detect_test.sv
module stereo_zero_detect_test;
  localparam int SAMPLE_W = 24;
  localparam int RUN_LEN  = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameStrobe = 1'b0;
  logic signed [SAMPLE_W-1:0] leftSample  = '0;
  logic signed [SAMPLE_W-1:0] rightSample = '0;
  logic zeroFlag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  typedef struct {
    logic  flag;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  int refCount = 0;
  logic refFlag = 1'b0;
  string curReq = "R2";
  int gap = 1;

  always #10 clk = ~clk;  // 50 MHz

  stereo_zero_detect #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) uut (
    .clk(clk), .rst(rst), .frameStrobe(frameStrobe),
    .leftSample(leftSample), .rightSample(rightSample), .zeroFlag(zeroFlag)
  );

  task automatic checkNow(input logic exp, input string req);
    checks++;
    if (zeroFlag !== exp) begin
      fails++;
      $display("FAIL %s: zeroFlag=%b expected=%b at cycle %0d", req, zeroFlag, exp, cycles);
    end
  endtask

  // driver: one frame, then gap idle cycles with junk samples (R1)
  task automatic sendFrame(input logic signed [SAMPLE_W-1:0] l,
                           input logic signed [SAMPLE_W-1:0] r);
    expItem_t it;
    if (l == 0 && r == 0) begin
      if (refCount < RUN_LEN) refCount++;
      refFlag = (refCount >= RUN_LEN);
    end else begin
      refCount = 0;
      refFlag  = 1'b0;
    end
    it.flag = refFlag;
    it.req  = curReq;
    expQ.push_back(it);
    frameStrobe = 1'b1;
    leftSample  = l;
    rightSample = r;
    @(negedge clk);
    frameStrobe = 1'b0;
    for (int i = 0; i < gap; i++) begin
      leftSample  = SAMPLE_W'(24'h5A5A5A + i);
      rightSample = SAMPLE_W'(-7 - i);
      @(negedge clk);
    end
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) sendFrame('0, '0);
  endtask

  // monitor: compare after every strobed edge
  initial begin
    forever begin
      @(posedge clk);
      if (frameStrobe && !rst) begin
        expItem_t it;
        @(negedge clk);
        it = expQ.pop_front();
        checks++;
        if (zeroFlag !== it.flag) begin
          fails++;
          $display("FAIL %s: zeroFlag=%b expected=%b at cycle %0d", it.req, zeroFlag, it.flag, cycles);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected<=190000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkNow(1'b0, "R7");  // reset state

    // R2: no flag after RUN_LEN-1 zero frames, flag on the RUN_LEN-th
    curReq = "R2";
    zeros(RUN_LEN - 1);
    checkNow(1'b0, "R2");
    zeros(1);
    checkNow(1'b1, "R2");

    // R1: junk between strobes and a long idle stretch leave flag up
    curReq = "R1";
    leftSample = 24'sh7FFFFF; rightSample = -24'sd1;
    repeat (20) @(negedge clk);
    checkNow(1'b1, "R1");

    // R6: well past twice the threshold, with a wider strobe spacing
    curReq = "R6";
    gap = 2;
    zeros(RUN_LEN + 200);
    gap = 1;
    checkNow(1'b1, "R6");

    // R4 + R3: left nonzero only, right zero
    curReq = "R4";
    sendFrame(24'sd1, '0);
    checkNow(1'b0, "R4");

    // R5 + R3: run restarted; right-only nonzero just before the limit
    curReq = "R3";
    zeros(RUN_LEN - 1);
    checkNow(1'b0, "R5");
    sendFrame('0, -24'sd3);
    checkNow(1'b0, "R3");

    curReq = "R5";
    zeros(RUN_LEN - 1);
    checkNow(1'b0, "R5");
    zeros(1);
    checkNow(1'b1, "R5");
    sendFrame(-24'sd8388608, 24'sd100);
    checkNow(1'b0, "R4");

    // R7: reset while the flag is up
    curReq = "R7";
    zeros(RUN_LEN);
    checkNow(1'b1, "R7");
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    refCount = 0; refFlag = 1'b0;
    checkNow(1'b0, "R7");
    zeros(RUN_LEN - 1);
    checkNow(1'b0, "R7");
    zeros(1);
    checkNow(1'b1, "R7");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d pending, expected 0", expQ.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule